// File: doc/BRIEF.md
# One-Position Shifter and Rotator

This block moves a data word by exactly one bit position, or leaves it alone, within the same cycle. A three-bit operation code says whether a move happens, which way it goes, and whether the bit that falls off one end is lost or wraps round to the other end. No register lies anywhere on the path.

For a plain move, two serial fill inputs supply the bit that enters the vacated end: one for the low end on a move toward the MSB, and one for the high end on a move toward the LSB. An arithmetic flag turns the plain move into a two's-complement one. Moving toward the MSB then brings in a zero. Moving toward the LSB then copies the sign bit into itself. Every output bit comes from its own four-input selector. Its four sources are its own input bit, its lower neighbour, its upper neighbour and an end value that is computed once for each end.

The operation code is laid out by bit position. Bit 2 set means move and clear means pass. Bit 1 set means toward the LSB and clear means toward the MSB. Bit 0 set means wrap and clear means plain. Left means toward the MSB and right means toward the LSB.

Top module: `shrot_unit`

## Requirements
- R1: With op_ctrl[2] = 0, data_out equals data_in whatever the other controls, fills and arith_en hold.
- R2: With op_ctrl[2:1] = 2'b10 (move left), data_out[i] = data_in[i-1] for every i from 1 to WIDTH-1, for both plain and wrap moves.
- R3: With op_ctrl[2:1] = 2'b11 (move right), data_out[i] = data_in[i+1] for every i from 0 to WIDTH-2, for both plain and wrap moves.
- R4: With op_ctrl = 3'b100 and arith_en = 0 (plain left shift), data_out[0] = fill_lsb.
- R5: With op_ctrl = 3'b110 and arith_en = 0 (plain right shift), data_out[WIDTH-1] = fill_msb.
- R6: With op_ctrl = 3'b100 and arith_en = 1 (arithmetic left shift), data_out[0] = 0 and fill_lsb has no effect.
- R7: With op_ctrl = 3'b110 and arith_en = 1 (arithmetic right shift), data_out[WIDTH-1] = data_in[WIDTH-1] and fill_msb has no effect.
- R8: With op_ctrl = 3'b101 (rotate left), data_out[0] = data_in[WIDTH-1], and fill_lsb, fill_msb and arith_en have no effect.
- R9: With op_ctrl = 3'b111 (rotate right), data_out[WIDTH-1] = data_in[0], and fill_lsb, fill_msb and arith_en have no effect.
- R10: data_out follows the inputs within the cycle in which they are applied, with no clock or register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be moved |
| op_ctrl | input | 3 | Bit 2 enables the move, bit 1 chooses right (1) or left (0), bit 0 chooses wrap (1) or plain (0) |
| fill_lsb | input | 1 | Bit that enters at bit 0 on a plain, non-arithmetic left shift |
| fill_msb | input | 1 | Bit that enters at bit WIDTH-1 on a plain, non-arithmetic right shift |
| arith_en | input | 1 | Selects two's-complement behaviour for plain shifts |
| data_out | output | WIDTH | Resulting word |

## Verification
The bench builds two copies of the unit. One has the default WIDTH of 8. The other has WIDTH of 2, where every bit is an end bit, so the selector for each bit has to use its end value and its single neighbour with no interior bit between them. Both copies receive every operation code under every combination of the two fills and the arithmetic flag, on corner words (all zeros, all ones, sign bit only, LSB only, alternating patterns) and on random words. This covers the cases where a fill, the arithmetic flag or the sign bit must decide the end bit, and the cases where they must be ignored.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    // Which source each output bit takes.
    typedef enum logic [1:0] {
        SRC_KEEP  = 2'd0,
        SRC_LOWER = 2'd1,
        SRC_UPPER = 2'd2,
        SRC_END   = 2'd3
    } src_sel_e;

    // Decoded operation.
    typedef struct packed {
        logic move;
        logic to_right;
        logic wrap;
    } op_word_t;

    // Values offered to the two end bits during a move.
    typedef struct packed {
        logic lsb_end;
        logic msb_end;
    } end_bits_t;

    // The op code layout is fixed by bit position.
    function automatic op_word_t unpack_op(input logic [2:0] code);
        op_word_t o;
        o.move     = code[2];
        o.to_right = code[1];
        o.wrap     = code[0];
        return o;
    endfunction

endpackage

// File: rtl/shrot_op_dec.sv
module shrot_op_dec
    import shrot_pkg::*;
(
    input  logic [2:0] op_ctrl,
    output op_word_t   op,
    output src_sel_e   sel_body,
    output src_sel_e   sel_lsb,
    output src_sel_e   sel_msb
);
    always_comb begin
        op = unpack_op(op_ctrl);
        if (!op.move) begin
            sel_body = SRC_KEEP;
        end else if (op.to_right) begin
            sel_body = SRC_UPPER;
        end else begin
            sel_body = SRC_LOWER;
        end
        // An end bit takes the end value only when the move empties it.
        sel_lsb = (op.move && !op.to_right) ? SRC_END : sel_body;
        sel_msb = (op.move &&  op.to_right) ? SRC_END : sel_body;
    end
endmodule

// File: rtl/shrot_end_fill.sv
module shrot_end_fill
    import shrot_pkg::*;
(
    input  op_word_t  op,
    input  logic      arith_en,
    input  logic      word_lsb,
    input  logic      word_msb,
    input  logic      fill_lsb,
    input  logic      fill_msb,
    output end_bits_t ends
);
    always_comb begin
        if (op.wrap) begin
            ends.lsb_end = word_msb;
            ends.msb_end = word_lsb;
        end else if (arith_en) begin
            ends.lsb_end = 1'b0;
            ends.msb_end = word_msb;
        end else begin
            ends.lsb_end = fill_lsb;
            ends.msb_end = fill_msb;
        end
    end
endmodule

// File: rtl/shrot_mux4.sv
module shrot_mux4
    import shrot_pkg::*;
(
    input  src_sel_e sel,
    input  logic     own_bit,
    input  logic     lower_bit,
    input  logic     upper_bit,
    input  logic     end_bit,
    output logic     y
);
    always_comb begin
        unique case (sel)
            SRC_KEEP:  y = own_bit;
            SRC_LOWER: y = lower_bit;
            SRC_UPPER: y = upper_bit;
            SRC_END:   y = end_bit;
            default:   y = own_bit;
        endcase
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [2:0]       op_ctrl,
    input  logic             fill_lsb,
    input  logic             fill_msb,
    input  logic             arith_en,
    output logic [WIDTH-1:0] data_out
);
    localparam int MSB = WIDTH - 1;

    op_word_t  op;
    src_sel_e  sel_body;
    src_sel_e  sel_lsb;
    src_sel_e  sel_msb;
    end_bits_t ends;

    shrot_op_dec u_dec (
        .op_ctrl  (op_ctrl),
        .op       (op),
        .sel_body (sel_body),
        .sel_lsb  (sel_lsb),
        .sel_msb  (sel_msb)
    );

    shrot_end_fill u_ends (
        .op       (op),
        .arith_en (arith_en),
        .word_lsb (data_in[0]),
        .word_msb (data_in[MSB]),
        .fill_lsb (fill_lsb),
        .fill_msb (fill_msb),
        .ends     (ends)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            shrot_mux4 u_mux (
                .sel       (sel_lsb),
                .own_bit   (data_in[i]),
                .lower_bit (1'b0),
                .upper_bit (data_in[i+1]),
                .end_bit   (ends.lsb_end),
                .y         (data_out[i])
            );
        end else if (i == MSB) begin : g_high
            shrot_mux4 u_mux (
                .sel       (sel_msb),
                .own_bit   (data_in[i]),
                .lower_bit (data_in[i-1]),
                .upper_bit (1'b0),
                .end_bit   (ends.msb_end),
                .y         (data_out[i])
            );
        end else begin : g_mid
            shrot_mux4 u_mux (
                .sel       (sel_body),
                .own_bit   (data_in[i]),
                .lower_bit (data_in[i-1]),
                .upper_bit (data_in[i+1]),
                .end_bit   (1'b0),
                .y         (data_out[i])
            );
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] data_in,
    input logic [2:0]       op_ctrl,
    input logic             fill_lsb,
    input logic             fill_msb,
    input logic             arith_en,
    input logic [WIDTH-1:0] data_out
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (!$isunknown({data_in, op_ctrl, fill_lsb, fill_msb, arith_en})) begin
            if (!op_ctrl[2]) begin
                AST_PASS_THROUGH: assert (data_out == data_in); // R1
            end
            if (op_ctrl[2:1] == 2'b10) begin
                AST_LEFT_BODY: assert (data_out[MSB:1] == data_in[MSB-1:0]); // R2
            end
            if (op_ctrl[2:1] == 2'b11) begin
                AST_RIGHT_BODY: assert (data_out[MSB-1:0] == data_in[MSB:1]); // R3
            end
            if (op_ctrl == 3'b100 && !arith_en) begin
                AST_LEFT_FILL: assert (data_out[0] == fill_lsb); // R4
            end
            if (op_ctrl == 3'b110 && !arith_en) begin
                AST_RIGHT_FILL: assert (data_out[MSB] == fill_msb); // R5
            end
            if (op_ctrl == 3'b100 && arith_en) begin
                AST_ARITH_LEFT_ZERO: assert (data_out[0] == 1'b0); // R6
            end
            if (op_ctrl == 3'b110 && arith_en) begin
                AST_ARITH_RIGHT_SIGN: assert (data_out[MSB] == data_in[MSB]); // R7
            end
            if (op_ctrl == 3'b101) begin
                AST_ROTL_WRAP: assert (data_out[0] == data_in[MSB]); // R8
            end
            if (op_ctrl == 3'b111) begin
                AST_ROTR_WRAP: assert (data_out[MSB] == data_in[0]); // R9
            end
        end
    end
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    localparam int WIDE   = 8;
    localparam int NARROW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [WIDE-1:0] d_in = '0;
    logic [2:0]      ctrl = '0;
    logic            f_lsb = 1'b0;
    logic            f_msb = 1'b0;
    logic            ar = 1'b0;
    logic [WIDE-1:0]   q_wide;
    logic [NARROW-1:0] q_narrow;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    shrot_unit #(.WIDTH(WIDE)) u_dut (
        .data_in (d_in), .op_ctrl (ctrl), .fill_lsb (f_lsb),
        .fill_msb (f_msb), .arith_en (ar), .data_out (q_wide)
    );

    shrot_unit #(.WIDTH(NARROW)) u_dut_narrow (
        .data_in (d_in[NARROW-1:0]), .op_ctrl (ctrl), .fill_lsb (f_lsb),
        .fill_msb (f_msb), .arith_en (ar), .data_out (q_narrow)
    );

    // Behavioural reference built on integer arithmetic.
    function automatic logic [15:0] ref_model(input int w, input logic [15:0] d,
                                              input logic [2:0] c, input logic fl,
                                              input logic fm, input logic a);
        logic [15:0] mask;
        logic [15:0] dm;
        logic [15:0] r;
        logic        top;
        mask = 16'((32'd1 << w) - 1);
        dm   = d & mask;
        top  = dm[w-1];
        if (!c[2]) return dm;
        if (!c[1]) begin
            r = (dm << 1) & mask;
            if (c[0])      r[0] = top;
            else if (a)    r[0] = 1'b0;
            else           r[0] = fl;
        end else begin
            r = dm >> 1;
            if (c[0])      r[w-1] = dm[0];
            else if (a)    r[w-1] = top;
            else           r[w-1] = fm;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic a);
        if (!c[2])        return "R1";
        if (c == 3'b101)  return "R2/R8";
        if (c == 3'b111)  return "R3/R9";
        if (c == 3'b100)  return a ? "R2/R6" : "R2/R4";
        return a ? "R3/R7" : "R3/R5";
    endfunction

    task automatic compare(input string tag, input string which,
                           input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s (%s) ctrl=%b ar=%b fl=%b fm=%b d=%h got=%h exp=%h",
                     tag, which, ctrl, ar, f_lsb, f_msb, d_in, got, exp);
        end
    endtask

    // Drive on the rising edge, check on the falling edge (R10: same cycle).
    task automatic apply(input logic [WIDE-1:0] d, input logic [2:0] c,
                         input logic fl, input logic fm, input logic a);
        @(posedge clk);
        d_in = d; ctrl = c; f_lsb = fl; f_msb = fm; ar = a;
        @(negedge clk);
        compare({tag_of(c, a), " R10"}, "w8", 16'(q_wide),
                ref_model(WIDE, 16'(d), c, fl, fm, a));
        compare({tag_of(c, a), " R10"}, "w2", 16'(q_narrow),
                ref_model(NARROW, 16'(d), c, fl, fm, a));
    endtask

    task automatic sweep(input logic [WIDE-1:0] d);
        for (int k = 0; k < 64; k++) begin
            apply(d, k[2:0], k[3], k[4], k[5]);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-time state: all-zero inputs give an all-zero word (R1).
        compare("R1", "reset w8", 16'(q_wide), 16'h0000);
        compare("R1", "reset w2", 16'(q_narrow), 16'h0000);
        rst = 1'b0;

        sweep(8'h00);
        sweep(8'hFF);
        sweep(8'h80);   // sign bit only: R7 copies it, R6 drops it
        sweep(8'h01);   // wraps on right rotate (R9)
        sweep(8'hA5);
        sweep(8'h5A);
        sweep(8'h7F);
        for (int n = 0; n < 20; n++) begin
            sweep(8'($urandom));
        end
        finish_run();
    end
endmodule